// File: doc/BRIEF.md
# Centralized DMA Target Cycle Decoder

This block is the slave-side logic that lets one legacy card slot take part in a chipset-driven DMA scheme. The DMA sequencing lives entirely in a central controller. The block stays a pure bus target and contains no bus-master state machine. A single control register holds three things: a per-slot request enable, a global enable that always reads as 1 when the feature is built in, and a 3-bit channel select.

When the card raises its DMA request and the slot is enabled, the block forwards a request to the central controller. The controller answers with a one-cycle grant pulse that carries a channel number. If that number matches the configured channel, the block becomes granted.

While granted, the block claims target I/O cycles at four fixed offsets. It classifies each claimed cycle as normal or verify, with or without terminal count. Each claimed cycle produces an acknowledge and a strobe toward the card. The transfer width follows from the channel number alone.

Top module: `cdma_target`

## Requirements
- R1: After reset, `cfg_rd_data` reads 32'h0000_0008: the request enable (bit 19) is 0, the channel field (bits 18:16) is 0 and the global enable (bit 3) is 1. After reset `dma_req`, `io_ack`, `card_strobe` and `card_tc` are 0.
- R2: A write to the control register changes only bits 19 and 18:16. Bit 3 always reads 1, and every other bit reads 0. A write takes effect one clock after it is presented.
- R3: `dma_req` is 1 one clock after `card_dreq` is 1 while the request enable is 1 and the channel field is not 4. It is 0 whenever the request enable is 0.
- R4: `dma_req` is 0 one clock after `card_dreq` goes to 0.
- R5: A grant pulse (`gnt_valid`=1) is accepted only when `gnt_chan` equals the channel field and `dma_req` is 1. A grant for any other channel leaves DMA cycles unclaimed.
- R6: While granted, an I/O read or write at offset 8'h00 is claimed as normal without terminal count. At offset 8'h04 it is claimed as normal with terminal count. A claimed cycle raises `io_ack` and `card_strobe` for one clock, one clock after the access. `card_tc` is 1 in that clock only for a terminal-count offset.
- R7: While granted, an I/O read at offset 8'h C0 is claimed as verify without terminal count, and a read at 8'h C4 as verify with terminal count. `cyc_verify`=1 marks both in the acknowledge clock. Writes to either verify offset are never claimed.
- R8: With channel field 4, `dma_req` stays 0 and no I/O cycle is claimed.
- R9: The granted state ends after a claimed terminal-count cycle, or when `card_dreq` is 0. Later DMA cycles are not claimed until a new grant is accepted.
- R10: `xfer_wide` equals bit 18 of the control register (0 = 8-bit channels 0–3, 1 = 16-bit channels 5–7). In the acknowledge clock `byte_en` is 2'b01 for 8-bit and 2'b11 for 16-bit transfers. It is 2'b00 otherwise.
- R11: Without a grant, or at any offset other than the four DMA offsets, no `io_ack` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 32 | Control register write data |
| cfg_rd_data | output | 32 | Control register read value |
| card_dreq | input | 1 | DMA request from the card |
| dma_req | output | 1 | Request toward the central DMA controller |
| gnt_valid | input | 1 | One-cycle grant pulse |
| gnt_chan | input | 3 | Channel carried by the grant |
| io_valid | input | 1 | One-cycle target I/O access |
| io_write | input | 1 | 1 = I/O write, 0 = I/O read |
| io_addr | input | 8 | I/O offset of the access |
| io_ack | output | 1 | Access claimed (one clock after the access) |
| card_strobe | output | 1 | Transfer strobe toward the card |
| card_tc | output | 1 | Terminal-count pulse toward the card |
| cyc_verify | output | 1 | Claimed cycle is a verify cycle |
| xfer_wide | output | 1 | 0 = 8-bit, 1 = 16-bit transfers |
| byte_en | output | 2 | Active byte lanes of the claimed cycle |

## Verification
The decoder is driven with all four DMA offsets as reads and as writes, and with an offset outside the set. This separates the normal/verify classification, the terminal-count flag and the write rejection at verify offsets. Accesses are also sent before any grant, after a grant for the wrong channel, after a terminal-count cycle and after a request drop. These show that claiming depends on the grant state and not on the address alone. Channel values 1, 5 and 4 separate the 8-bit lane, the 16-bit lane and the unused-channel rejection. Configuring with the request enable off shows that the request path is gated independently of the card request.

// File: rtl/cdma_pkg.sv
// Package: shared constants and the cycle classification type for the
// centralized DMA target. Assumes an 8-bit I/O offset and a 3-bit channel.
package cdma_pkg;
    localparam int CHAN_W = 3;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int BE_W   = 2;

    typedef enum logic [2:0] {
        CYC_NONE      = 3'd0,
        CYC_NORMAL    = 3'd1,
        CYC_NORMAL_TC = 3'd2,
        CYC_VERIFY    = 3'd3,
        CYC_VERIFY_TC = 3'd4
    } cyc_kind_e;
endpackage

// File: rtl/cdma_ctrl_reg.sv
// Control register: holds the slot request enable and the channel field.
// Assumes one write port with no byte enables. The global enable bit is
// hardwired from HAS_DMA and cannot be written.
module cdma_ctrl_reg #(
    parameter int DATA_W     = 32,
    parameter int CHAN_W     = 3,
    parameter int REQ_EN_BIT = 19,
    parameter int CHAN_LSB   = 16,
    parameter int GLB_EN_BIT = 3,
    parameter bit HAS_DMA    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              req_en,
    output logic              glb_en,
    output logic [CHAN_W-1:0] chan
);
    localparam logic [DATA_W-1:0] ONE      = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] CHAN_MSK = ((ONE << CHAN_W) - ONE) << CHAN_LSB;
    localparam logic [DATA_W-1:0] WR_MASK  = CHAN_MSK | (ONE << REQ_EN_BIT);
    localparam logic [DATA_W-1:0] GLB_VAL  = HAS_DMA ? (ONE << GLB_EN_BIT) : '0;

    logic [DATA_W-1:0] cfg_q;

    // Store the writable fields; everything else is held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_en)
            cfg_q <= wr_data & WR_MASK;
    end

    assign rd_data = cfg_q | GLB_VAL;
    assign req_en  = rd_data[REQ_EN_BIT];
    assign glb_en  = rd_data[GLB_EN_BIT];
    assign chan    = rd_data[CHAN_LSB +: CHAN_W];
endmodule

// File: rtl/cdma_req_grant.sv
// Request and grant tracking. It registers the request toward the central
// controller and holds the granted state. Assumes grants are one-cycle
// pulses. Clearing has priority over a new grant.
module cdma_req_grant #(
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_dreq,
    input  logic              req_en,
    input  logic              glb_en,
    input  logic              chan_ok,
    input  logic [CHAN_W-1:0] chan,
    input  logic              gnt_valid,
    input  logic [CHAN_W-1:0] gnt_chan,
    input  logic              tc_done,
    output logic              dma_req,
    output logic              granted
);
    logic gnt_hit;
    assign gnt_hit = gnt_valid && dma_req && (gnt_chan == chan);

    // Forward the card request when the slot is enabled and the channel is legal.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dma_req <= 1'b0;
        else
            dma_req <= card_dreq && req_en && glb_en && chan_ok;
    end

    // Hold the grant until terminal count or until the request drops.
    always_ff @(posedge clk) begin
        if (!rst_n)
            granted <= 1'b0;
        else if (!card_dreq || tc_done)
            granted <= 1'b0;
        else if (gnt_hit)
            granted <= 1'b1;
    end
endmodule

// File: rtl/cdma_cycle_decode.sv
// Cycle decoder: matches the four fixed DMA offsets, classifies the access
// and issues registered one-clock acknowledge and card strobes. Assumes each
// access is presented for exactly one clock.
module cdma_cycle_decode
    import cdma_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter int              BE_W       = 2,
    parameter logic [ADDR_W-1:0] OFS_NORM    = 8'h00,
    parameter logic [ADDR_W-1:0] OFS_NORM_TC = 8'h04,
    parameter logic [ADDR_W-1:0] OFS_VER     = 8'hC0,
    parameter logic [ADDR_W-1:0] OFS_VER_TC  = 8'hC4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              granted,
    input  logic              card_dreq,
    input  logic              chan_ok,
    input  logic              wide,
    output logic              tc_done,
    output logic              io_ack,
    output logic              card_strobe,
    output logic              card_tc,
    output logic              cyc_verify,
    output logic [BE_W-1:0]   byte_en
);
    cyc_kind_e kind;
    logic      claim;
    logic      is_tc;
    logic      is_ver;
    logic [BE_W-1:0] lanes;

    // Classify the offset; verify offsets accept reads only.
    always_comb begin
        kind = CYC_NONE;
        unique case (io_addr)
            OFS_NORM:    kind = CYC_NORMAL;
            OFS_NORM_TC: kind = CYC_NORMAL_TC;
            OFS_VER:     kind = io_write ? CYC_NONE : CYC_VERIFY;
            OFS_VER_TC:  kind = io_write ? CYC_NONE : CYC_VERIFY_TC;
            default:     kind = CYC_NONE;
        endcase
    end

    assign is_tc   = (kind == CYC_NORMAL_TC) || (kind == CYC_VERIFY_TC);
    assign is_ver  = (kind == CYC_VERIFY) || (kind == CYC_VERIFY_TC);
    assign claim   = io_valid && granted && card_dreq && chan_ok && (kind != CYC_NONE);
    assign tc_done = claim && is_tc;

    // Lane mask: the lowest byte for narrow transfers, all lanes for wide ones.
    generate
        if (BE_W > 1) begin : g_multi
            assign lanes = wide ? {BE_W{1'b1}} : {{(BE_W-1){1'b0}}, 1'b1};
        end else begin : g_single
            assign lanes = 1'b1;
        end
    endgenerate

    // Register the one-clock response toward the bus and the card.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_ack      <= 1'b0;
            card_strobe <= 1'b0;
            card_tc     <= 1'b0;
            cyc_verify  <= 1'b0;
            byte_en     <= '0;
        end else begin
            io_ack      <= claim;
            card_strobe <= claim;
            card_tc     <= claim && is_tc;
            cyc_verify  <= claim && is_ver;
            byte_en     <= claim ? lanes : '0;
        end
    end
endmodule

// File: rtl/cdma_target.sv
// Top of the centralized DMA target: control register, request/grant
// tracking and cycle decoder. Assumes a single card slot and that the
// central controller drives all DMA sequencing.
module cdma_target
    import cdma_pkg::*;
#(
    parameter logic [CHAN_W-1:0] UNUSED_CHAN = 3'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [DATA_W-1:0] cfg_wr_data,
    output logic [DATA_W-1:0] cfg_rd_data,
    input  logic              card_dreq,
    output logic              dma_req,
    input  logic              gnt_valid,
    input  logic [CHAN_W-1:0] gnt_chan,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              io_ack,
    output logic              card_strobe,
    output logic              card_tc,
    output logic              cyc_verify,
    output logic              xfer_wide,
    output logic [BE_W-1:0]   byte_en
);
    logic              req_en;
    logic              glb_en;
    logic [CHAN_W-1:0] chan;
    logic              chan_ok;
    logic              granted;
    logic              tc_done;

    assign chan_ok   = (chan != UNUSED_CHAN);
    assign xfer_wide = chan[CHAN_W-1];

    cdma_ctrl_reg #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .rd_data (cfg_rd_data),
        .req_en  (req_en),
        .glb_en  (glb_en),
        .chan    (chan)
    );

    cdma_req_grant #(.CHAN_W(CHAN_W)) u_rg (
        .clk       (clk),
        .rst_n     (rst_n),
        .card_dreq (card_dreq),
        .req_en    (req_en),
        .glb_en    (glb_en),
        .chan_ok   (chan_ok),
        .chan      (chan),
        .gnt_valid (gnt_valid),
        .gnt_chan  (gnt_chan),
        .tc_done   (tc_done),
        .dma_req   (dma_req),
        .granted   (granted)
    );

    cdma_cycle_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .io_valid    (io_valid),
        .io_write    (io_write),
        .io_addr     (io_addr),
        .granted     (granted),
        .card_dreq   (card_dreq),
        .chan_ok     (chan_ok),
        .wide        (xfer_wide),
        .tc_done     (tc_done),
        .io_ack      (io_ack),
        .card_strobe (card_strobe),
        .card_tc     (card_tc),
        .cyc_verify  (cyc_verify),
        .byte_en     (byte_en)
    );
endmodule

// File: rtl/cdma_target_chk.sv
// Checker for cdma_target: temporal properties on the top-level ports.
// Assumes the default field positions (channel in bits 18:16).
module cdma_target_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cfg_rd_data,
    input logic        card_dreq,
    input logic        dma_req,
    input logic        io_write,
    input logic        io_ack,
    input logic        card_strobe,
    input logic        card_tc,
    input logic        cyc_verify,
    input logic        xfer_wide,
    input logic [1:0]  byte_en
);
    // R3
    req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $past(card_dreq));

    // R4
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !card_dreq |=> !dma_req);

    // R8
    chan_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data[18:16] == 3'd4) |=> !dma_req);

    // R6
    tc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_tc |=> !card_tc);

    // R6
    tc_has_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_tc |-> (io_ack && card_strobe));

    // R7
    verify_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_ack && cyc_verify) |-> $past(!io_write));

    // R10
    lanes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_ack |-> (byte_en == 2'b00));

    // R10
    lanes_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_ack |-> byte_en[0]);

    // R10
    wide_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_wide == cfg_rd_data[18]);

    // R2
    glb_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[3]);
endmodule

bind cdma_target cdma_target_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rd_data (cfg_rd_data),
    .card_dreq   (card_dreq),
    .dma_req     (dma_req),
    .io_write    (io_write),
    .io_ack      (io_ack),
    .card_strobe (card_strobe),
    .card_tc     (card_tc),
    .cyc_verify  (cyc_verify),
    .xfer_wide   (xfer_wide),
    .byte_en     (byte_en)
);

// File: tb/sim_cdma_target.sv
// Directed bench for cdma_target: one task per scenario, each checking itself.
module sim_cdma_target;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        card_dreq = 1'b0;
    logic        dma_req;
    logic        gnt_valid = 1'b0;
    logic [2:0]  gnt_chan = '0;
    logic        io_valid = 1'b0;
    logic        io_write = 1'b0;
    logic [7:0]  io_addr = '0;
    logic        io_ack;
    logic        card_strobe;
    logic        card_tc;
    logic        cyc_verify;
    logic        xfer_wide;
    logic [1:0]  byte_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cdma_target u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .card_dreq(card_dreq), .dma_req(dma_req),
        .gnt_valid(gnt_valid), .gnt_chan(gnt_chan), .io_valid(io_valid),
        .io_write(io_write), .io_addr(io_addr), .io_ack(io_ack),
        .card_strobe(card_strobe), .card_tc(card_tc), .cyc_verify(cyc_verify),
        .xfer_wide(xfer_wide), .byte_en(byte_en)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] d);
        @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = d;
        @(negedge clk); cfg_wr_en = 1'b0;
    endtask

    task automatic set_dreq(input bit v);
        @(negedge clk); card_dreq = v;
        @(negedge clk);
    endtask

    task automatic grant(input logic [2:0] ch);
        @(negedge clk); gnt_valid = 1'b1; gnt_chan = ch;
        @(negedge clk); gnt_valid = 1'b0;
    endtask

    // Presents one access and samples the registered response a clock later.
    task automatic access(input logic [7:0] a, input bit wr, output logic [5:0] r);
        @(negedge clk); io_valid = 1'b1; io_addr = a; io_write = wr;
        @(negedge clk); io_valid = 1'b0;
        r = {io_ack, card_strobe, card_tc, cyc_verify, byte_en};
    endtask

    task automatic t_reset();
        chk(cfg_rd_data == 32'h8, "R1 reg", cfg_rd_data, 32'h8);
        chk({dma_req, io_ack, card_strobe, card_tc} == 4'b0, "R1 outputs",
            {dma_req, io_ack, card_strobe, card_tc}, 0);
    endtask

    task automatic t_register();
        cfg_write(32'h0);
        chk(cfg_rd_data == 32'h8, "R2 write zero", cfg_rd_data, 32'h8);
        cfg_write(32'hFFFF_FFFF);
        chk(cfg_rd_data == 32'h000F_0008, "R2 write ones", cfg_rd_data, 32'h000F_0008);
    endtask

    task automatic t_narrow();
        logic [5:0] r;
        cfg_write(32'h0009_0000);
        chk(xfer_wide == 1'b0, "R10 narrow width", xfer_wide, 0);
        set_dreq(1'b1);
        chk(dma_req == 1'b1, "R3 request", dma_req, 1);
        access(8'h00, 1'b0, r);
        chk(r[5] == 1'b0, "R11 no grant", r, 0);
        grant(3'd2);
        access(8'h00, 1'b0, r);
        chk(r[5] == 1'b0, "R5 wrong channel", r, 0);
        grant(3'd1);
        access(8'h00, 1'b0, r);
        chk(r == 6'b110001, "R6 normal read", r, 6'b110001);
        access(8'h00, 1'b1, r);
        chk(r == 6'b110001, "R6 normal write", r, 6'b110001);
        access(8'h08, 1'b0, r);
        chk(r == 6'b0, "R11 other offset", r, 0);
        access(8'hC0, 1'b0, r);
        chk(r == 6'b110101, "R7 verify read", r, 6'b110101);
        access(8'hC0, 1'b1, r);
        chk(r == 6'b0, "R7 verify write", r, 0);
        access(8'hC4, 1'b1, r);
        chk(r == 6'b0, "R7 verify tc write", r, 0);
        access(8'hC4, 1'b0, r);
        chk(r == 6'b111101, "R7 verify tc read", r, 6'b111101);
        @(negedge clk);
        chk(card_tc == 1'b0, "R6 tc single clock", card_tc, 0);
        access(8'h00, 1'b0, r);
        chk(r[5] == 1'b0, "R9 cleared by tc", r, 0);
        set_dreq(1'b0);
        chk(dma_req == 1'b0, "R4 request drop", dma_req, 0);
    endtask

    task automatic t_wide();
        logic [5:0] r;
        cfg_write(32'h000D_0000);
        chk(xfer_wide == 1'b1, "R10 wide width", xfer_wide, 1);
        set_dreq(1'b1);
        grant(3'd5);
        access(8'h04, 1'b1, r);
        chk(r == 6'b111011, "R6 R10 wide tc write", r, 6'b111011);
        grant(3'd5);
        set_dreq(1'b0);
        set_dreq(1'b1);
        access(8'h00, 1'b0, r);
        chk(r[5] == 1'b0, "R9 cleared by request drop", r, 0);
        set_dreq(1'b0);
    endtask

    task automatic t_unused();
        logic [5:0] r;
        cfg_write(32'h000C_0000);
        set_dreq(1'b1);
        chk(dma_req == 1'b0, "R8 no request", dma_req, 0);
        grant(3'd4);
        access(8'h00, 1'b0, r);
        chk(r[5] == 1'b0, "R8 no claim", r, 0);
        set_dreq(1'b0);
    endtask

    task automatic t_disabled();
        cfg_write(32'h0001_0000);
        set_dreq(1'b1);
        chk(dma_req == 1'b0, "R3 enable off", dma_req, 0);
        set_dreq(1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_register();
        t_narrow();
        t_wide();
        t_unused();
        t_disabled();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule